// File: doc/BRIEF.md
# Status Register and Write-Protect Controller

This block keeps the status byte of a serial non-volatile memory and rules on every write. A serial front-end decodes each instruction and hands it over as a one-cycle command: set or clear the write-enable latch, read the status byte, load the status byte, or request a data write at an address. The block then does two things. It updates the write-enable latch, the two block-protect bits and the status-freeze bit. It also times the self-timed write cycle that follows each accepted write or status load.

A data write is granted only when the write-enable latch is set and the address lies outside the area the block-protect bits guard. The status byte itself can be frozen: while the freeze bit is 1 and the active-low write-protect pin is held low, status loads are refused. A granted write produces a one-cycle permit pulse, which the array model uses to start programming. The status byte is always present on an output so that the front-end can shift it out for a status read.

Top module: `sr_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and `wr_permit` is low.
- R2: Command code 1 sets the write-enable latch (status bit 1). Command code 2 clears it. Each change is visible in the cycle after the command.
- R3: A write request (code 5) made while the latch is set and the address is unprotected pulses `wr_permit` high for exactly one cycle, in the cycle after the request. Status bit 0 (busy) is then set for exactly `WR_CYCLES` cycles.
- R4: When the busy bit falls, the write-enable latch is cleared in the same cycle.
- R5: A write request or a status load (code 4) made while the latch is clear has no effect. A refused request of either kind clears the latch, raises no permit and starts no busy period.
- R6: Block-protect bits 3:2 guard addresses as follows: 00 guards nothing; 01 guards the top quarter (the two address MSBs are 11); 10 guards the top half (the address MSB is 1); 11 guards every address. A write to a guarded address is refused.
- R7: An accepted status load copies data bit 7 into status bit 7 and data bits 3:2 into status bits 3:2. It ignores the other data bits and starts a busy period of `WR_CYCLES` cycles.
- R8: While status bit 7 is 1 and `wp_n` is low, a status load is refused and bits 7 and 3:2 keep their values. While bit 7 is 0, the level of `wp_n` has no effect on status loads.
- R9: While the busy bit is set, every command except a status read (code 3) is ignored.
- R10: Status bits 6:4 always read 0. A status read (code 3) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code: 1 latch set, 2 latch clear, 3 status read, 4 status load, 5 write request |
| cmd_wdata | input | 8 | Data byte for a status load |
| cmd_addr | input | ADDR_W | Target address for a write request |
| wp_n | input | 1 | Write-protect pin, active low |
| wr_permit | output | 1 | One-cycle grant of a data write |
| status | output | 8 | Status byte: b7 freeze, b3:b2 block protect, b1 latch, b0 busy |

## Verification
The bench builds the block with `WR_CYCLES` = 8 and `ADDR_W` = 6. With a busy period of eight cycles, the busy length can be counted cycle by cycle, and commands can be issued inside that window. With six address bits, the quarter and half boundaries fall at addresses 48 and 32. Addresses on both sides of each boundary can therefore be tried directly under every protect setting.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SETEN = 3'd1,
        OP_CLREN = 3'd2,
        OP_RDST  = 3'd3,
        OP_LDST  = 3'd4,
        OP_WRITE = 3'd5
    } op_e;

    typedef struct packed {
        logic       frz;     // status freeze bit (b7)
        logic [1:0] guard;   // block-protect field (b3:b2)
        logic       wen;     // write-enable latch (b1)
        logic       permit;  // registered write grant
    } ctl_s;

endpackage

// File: rtl/sr_wp_region.sv
module sr_wp_region #(
    parameter int ADDR_W = 15
) (
    input  logic [1:0]        guard,
    input  logic [ADDR_W-1:0] addr,
    output logic              blocked
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        case (guard)
            2'b00:   blocked = 1'b0;
            2'b01:   blocked = addr[TOP] & addr[TOP-1];
            2'b10:   blocked = addr[TOP];
            default: blocked = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_wp_timer.sv
module sr_wp_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start && !tmr_q.busy) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = LOAD;
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0);
endmodule

// File: rtl/sr_wp_ctrl.sv
module sr_wp_ctrl #(
    parameter int ADDR_W    = 15,
    parameter int WR_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_wdata,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wp_n,
    output logic              wr_permit,
    output logic [7:0]        status
);
    import sr_wp_pkg::*;

    ctl_s ctl_d, ctl_q;
    logic blocked, busy, done, start, frozen;
    op_e  op;

    assign op     = op_e'(cmd_op);
    assign frozen = ctl_q.frz & ~wp_n;

    sr_wp_region #(.ADDR_W(ADDR_W)) u_region (
        .guard   (ctl_q.guard),
        .addr    (cmd_addr),
        .blocked (blocked)
    );

    sr_wp_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.permit = 1'b0;
        start        = 1'b0;
        if (done) ctl_d.wen = 1'b0;
        if (cmd_valid && !busy) begin
            case (op)
                OP_SETEN: ctl_d.wen = 1'b1;
                OP_CLREN: ctl_d.wen = 1'b0;
                OP_LDST: begin
                    if (ctl_q.wen && !frozen) begin
                        ctl_d.frz   = cmd_wdata[7];
                        ctl_d.guard = cmd_wdata[3:2];
                        start       = 1'b1;
                    end else begin
                        ctl_d.wen = 1'b0;
                    end
                end
                OP_WRITE: begin
                    if (ctl_q.wen && !blocked) begin
                        ctl_d.permit = 1'b1;
                        start        = 1'b1;
                    end else begin
                        ctl_d.wen = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wr_permit = ctl_q.permit;
    assign status    = {ctl_q.frz, 3'b000, ctl_q.guard, ctl_q.wen, busy};
endmodule

// File: rtl/sr_wp_checker.sv
module sr_wp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       wp_n,
    input logic       wr_permit,
    input logic [7:0] status
);
    // R2: the latch only rises after a set command
    a_r2_wen_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(cmd_valid && cmd_op == 3'd1));

    // R3: a grant comes with the busy bit
    a_r3_permit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> status[0]);

    // R3: the grant lasts one cycle
    a_r3_permit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |=> !wr_permit);

    // R4: the latch is clear when busy ends
    a_r4_wen_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);

    // R5: a grant needs the latch set and the block idle beforehand
    a_r5_permit_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> ($past(status[1]) && !$past(status[0])));

    // R6: no grant while everything is guarded
    a_r6_all_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> ($past(status[3:2]) != 2'b11));

    // R8: frozen protection bits hold
    a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status[7]) && !$past(wp_n)) |-> ($stable(status[7]) && $stable(status[3:2])));

    // R9: protection bits hold while busy
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status[0]) |-> $stable(status[7:2]));

    // R10: reserved bits read zero
    a_r10_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:4] == 3'b000);
endmodule

bind sr_wp_ctrl sr_wp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wp_n      (wp_n),
    .wr_permit (wr_permit),
    .status    (status)
);

// File: tb/tb_sr_wp_ctrl.sv
`timescale 1ns/1ps
module tb_sr_wp_ctrl;
    localparam int AW  = 6;
    localparam int WRC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [7:0]    cmd_wdata = 8'h00;
    logic [AW-1:0] cmd_addr = '0;
    logic          wp_n = 1'b1;
    logic          wr_permit;
    logic [7:0]    status;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sr_wp_ctrl #(.ADDR_W(AW), .WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_addr(cmd_addr), .wp_n(wp_n),
        .wr_permit(wr_permit), .status(status)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one command for one cycle; returns just after it is captured
    task automatic issue(input logic [2:0] op, input logic [7:0] data, input logic [AW-1:0] addr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = data; cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3 * WRC && status[0]; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 status", status, 8'h00);
        chk("R1 permit", {7'd0, wr_permit}, 8'h00);
    endtask

    task automatic t_latch();
        issue(3'd1, 8'h00, '0);
        chk("R2 set latch", status, 8'h02);
        issue(3'd3, 8'h00, '0);
        chk("R10 status read no effect", status, 8'h02);
        issue(3'd2, 8'h00, '0);
        chk("R2 clear latch", status, 8'h00);
    endtask

    task automatic t_write_ok();
        issue(3'd1, 8'h00, '0);
        issue(3'd5, 8'h00, 6'd5);
        chk("R3 permit pulse", {7'd0, wr_permit}, 8'h01);
        chk("R3 busy+latch", status, 8'h03);
        for (int i = 0; i < WRC - 1; i++) begin
            @(negedge clk);
            chk("R3 busy length", status, 8'h03);
            if (i == 0) chk("R3 permit one cycle", {7'd0, wr_permit}, 8'h00);
        end
        @(negedge clk);
        chk("R4 latch cleared at end", status, 8'h00);
    endtask

    task automatic t_no_latch();
        issue(3'd5, 8'h00, 6'd5);
        chk("R5 write without latch permit", {7'd0, wr_permit}, 8'h00);
        chk("R5 write without latch status", status, 8'h00);
        issue(3'd4, 8'h8C, '0);
        chk("R5 load without latch", status, 8'h00);
    endtask

    task automatic load(input logic [7:0] data);
        issue(3'd1, 8'h00, '0);
        issue(3'd4, data, '0);
        wait_idle();
    endtask

    task automatic try_write(input logic [AW-1:0] addr, input bit ok, input logic [7:0] st, input string tag);
        issue(3'd1, 8'h00, '0);
        issue(3'd5, 8'h00, addr);
        chk(tag, {7'd0, wr_permit}, {7'd0, ok});
        chk(tag, status, ok ? (st | 8'h03) : st);
        wait_idle();
    endtask

    task automatic t_guard();
        load(8'h04);
        chk("R6 guard quarter set", status, 8'h04);
        try_write(6'd47, 1'b1, 8'h04, "R6 quarter below edge");
        try_write(6'd48, 1'b0, 8'h04, "R6 quarter at edge refused");
        load(8'h08);
        try_write(6'd31, 1'b1, 8'h08, "R6 half below edge");
        try_write(6'd32, 1'b0, 8'h08, "R6 half at edge refused");
        load(8'h0C);
        try_write(6'd0, 1'b0, 8'h0C, "R6 all guarded");
        load(8'h00);
        try_write(6'd63, 1'b1, 8'h00, "R6 none guarded top");
    endtask

    task automatic t_load();
        issue(3'd1, 8'h00, '0);
        issue(3'd4, 8'h73, '0);
        chk("R7 load ignores other bits", status, 8'h03);
        wait_idle();
        chk("R7 after load", status, 8'h00);
        issue(3'd1, 8'h00, '0);
        issue(3'd4, 8'hFF, '0);
        chk("R7 load all", status, 8'h8F);
        wait_idle();
        chk("R7 load all done", status, 8'h8C);
    endtask

    task automatic t_freeze();
        wp_n = 1'b0;
        issue(3'd1, 8'h00, '0);
        issue(3'd4, 8'h00, '0);
        chk("R8 frozen load refused", status, 8'h8C);
        wp_n = 1'b1;
        issue(3'd1, 8'h00, '0);
        issue(3'd4, 8'h00, '0);
        chk("R8 unfrozen load", status, 8'h03);
        wait_idle();
        wp_n = 1'b0;
        issue(3'd1, 8'h00, '0);
        issue(3'd4, 8'h08, '0);
        chk("R8 pin ignored when bit7 clear", status, 8'h0B);
        wait_idle();
        chk("R8 load done", status, 8'h08);
        wp_n = 1'b1;
        load(8'h00);
    endtask

    task automatic t_busy();
        issue(3'd1, 8'h00, '0);
        issue(3'd5, 8'h00, 6'd1);
        issue(3'd2, 8'h00, '0);
        chk("R9 clear ignored while busy", status, 8'h03);
        issue(3'd4, 8'h0C, '0);
        chk("R9 load ignored while busy", status, 8'h03);
        issue(3'd5, 8'h00, 6'd2);
        chk("R9 write ignored while busy", {7'd0, wr_permit}, 8'h00);
        wait_idle();
        chk("R9 end state", status, 8'h00);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_write_ok();
        t_no_latch();
        t_guard();
        t_load();
        t_freeze();
        t_busy();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule